// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the architectural state changes a processor core makes when it accepts a trap. Each request carries a trap type, the current program counter and next program counter, the window counters and the current processor-state word. From these the block produces the new state and a redirect target. It keeps the trap level and a stack of saved PC, nPC and trap type, one entry per level. It forces the processor-state word into its handler configuration, moves the current window pointer for window-management traps, and forms the handler fetch addresses from the trap base address.

The whole update takes effect at the clock edge that samples the request. A one-cycle strobe then presents the handler PC and nPC, the new window pointer and the new processor-state word. The saved entries can be read back through a combinational read port that is indexed by level. A request that arrives while the trap level already sits at its maximum pushes nothing. It raises a sticky error-mode flag instead, and the flag stays set until reset. Returning from a trap lies outside this block, so the trap level only goes down through reset.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the trap level is 0, error mode is 0, the redirect strobe is 0 and every saved stack entry reads as zero.
- R2: An accepted request raises the trap level by one. It writes the current PC, the current nPC and the 9-bit trap type into the stack entry at the new level, and that entry is read back through the read port at that level.
- R3: The new processor-state word is 10 bits: [0] red, [1] FPU enable, [2] address mask, [3] privileged, [4] interrupt enable, [5] alternate globals, [6] current little-endian, [7] trap little-endian, [9:8] memory model. On entry red=0, FPU enable equals the FPU-present strap, address mask=0, privileged=1, interrupt enable=0 and alternate globals=1. Bit [6] takes the incoming bit [7], and bits [9:7] pass through unchanged.
- R4: For trap type 0x024 the new window pointer is the current pointer plus 1, modulo the window count.
- R5: For trap types 0x080 through 0x0BF the new window pointer is the current pointer plus cansave plus 2, modulo the window count.
- R6: For trap types 0x0C0 through 0x0FF the new window pointer is the current pointer minus 1, modulo the window count. Every other type, including 0x034 and any type with bit 8 set, leaves the pointer unchanged.
- R7: The handler PC is base-address bits 63:15 in bits 63:15, then bit 14 = 1 when the trap level before entry was nonzero, then the trap type in bits 13:5, then zeros in bits 4:0.
- R8: The handler nPC equals the handler PC with bits 4:0 set to 0x04.
- R9: The redirect strobe is high for exactly the one cycle after each accepted request's sampling edge. Back-to-back requests give back-to-back strobes in request order.
- R10: A request taken while the trap level equals MAX_TL (default 5) leaves the trap level and the stack unchanged and gives no redirect strobe. It sets error mode, which stays set, and later requests are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled on the rising edge |
| trap_type | input | 9 | Trap type of the request |
| cur_pc | input | 64 | PC at the point of the trap |
| cur_npc | input | 64 | Next PC at the point of the trap |
| trap_base | input | 64 | Trap base address (bits 63:15 used) |
| cur_cwp | input | CWP_W | Current window pointer |
| cansave | input | CWP_W | Savable-window count |
| cur_pstate | input | 10 | Current processor-state word |
| fpu_present | input | 1 | Strap: hardware FPU fitted |
| rd_lvl | input | TL_W | Stack read level |
| tl | output | TL_W | Current trap level |
| err_mode | output | 1 | Sticky error mode |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 64 | Handler PC |
| redir_npc | output | 64 | Handler next PC |
| new_cwp | output | CWP_W | Window pointer after entry |
| new_pstate | output | 10 | Processor-state word after entry |
| rd_tpc | output | 64 | Saved PC at rd_lvl |
| rd_tnpc | output | 64 | Saved nPC at rd_lvl |
| rd_tt | output | 9 | Saved trap type at rd_lvl |

## Verification
The bench aims at the window-pointer wrap cases. It takes a clean-window trap from pointer 7, a spill whose sum runs past the window count, and a fill from pointer 0. A design that got these wrong would send the handler to the wrong window or saturate instead of wrapping. It also probes the level-nonzero bit on the first trap and on the nested ones, and a type with bit 8 set, which must not be taken for a fill. A misplaced vector bit would jump to the wrong table slot. Finally it drives a request at the maximum level followed by one more request. A faulty design would overwrite the top entry, wrap the level to zero, or emit a spurious redirect.

// File: rtl/trap_pkg.sv
// Shared types for the trap entry sequencer.
// Assumes a 10-bit processor-state word laid out as the struct below.
package trap_pkg;
    typedef struct packed {
        logic [1:0] mm;    // memory model
        logic       tle;   // trap little-endian
        logic       cle;   // current little-endian
        logic       ag;    // alternate globals
        logic       ie;    // interrupt enable
        logic       priv;  // privileged
        logic       am;    // address mask
        logic       pef;   // FPU enable
        logic       red;   // red state
    } pstate_t;

    localparam int TT_W   = 9;
    localparam int ADDR_W = 64;
endpackage

// File: rtl/trap_stack.sv
// Per-level storage of saved PC, nPC and trap type.
// Level 0 is never written. Reads outside 1..MAX_TL return zero.
module trap_stack #(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [TL_W-1:0]             wlvl,
    input  logic [trap_pkg::ADDR_W-1:0] wpc,
    input  logic [trap_pkg::ADDR_W-1:0] wnpc,
    input  logic [trap_pkg::TT_W-1:0]   wtt,
    input  logic [TL_W-1:0]             rlvl,
    output logic [trap_pkg::ADDR_W-1:0] rpc,
    output logic [trap_pkg::ADDR_W-1:0] rnpc,
    output logic [trap_pkg::TT_W-1:0]   rtt
);
    logic [trap_pkg::ADDR_W-1:0] pc_q  [MAX_TL];
    logic [trap_pkg::ADDR_W-1:0] npc_q [MAX_TL];
    logic [trap_pkg::TT_W-1:0]   tt_q  [MAX_TL];

    for (genvar g = 0; g < MAX_TL; g++) begin : g_lvl
        // Entry g holds level g+1; cleared on reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[g]  <= '0;
                npc_q[g] <= '0;
                tt_q[g]  <= '0;
            end else if (we && wlvl == TL_W'(g + 1)) begin
                pc_q[g]  <= wpc;
                npc_q[g] <= wnpc;
                tt_q[g]  <= wtt;
            end
        end
    end

    // Read mux by level.
    always_comb begin
        rpc  = '0;
        rnpc = '0;
        rtt  = '0;
        for (int i = 0; i < MAX_TL; i++) begin
            if (rlvl == TL_W'(i + 1)) begin
                rpc  = pc_q[i];
                rnpc = npc_q[i];
                rtt  = tt_q[i];
            end
        end
    end
endmodule

// File: rtl/trap_cwp_adj.sv
// Window-pointer adjustment by trap-type range.
// Assumes the window count is a power of two, so truncation is the modulo.
module trap_cwp_adj #(
    parameter int CWP_W = 3
) (
    input  logic [trap_pkg::TT_W-1:0] tt,
    input  logic [CWP_W-1:0]          cwp,
    input  logic [CWP_W-1:0]          cansave,
    output logic [CWP_W-1:0]          cwp_out
);
    localparam logic [CWP_W-1:0] ONE = CWP_W'(1);
    localparam logic [CWP_W-1:0] TWO = CWP_W'(2);

    // Select clean, spill, fill or pass-through.
    always_comb begin
        if (tt == 9'h024)
            cwp_out = cwp + ONE;
        else if (tt[8:6] == 3'b010)
            cwp_out = cwp + cansave + TWO;
        else if (tt[8:6] == 3'b011)
            cwp_out = cwp - ONE;
        else
            cwp_out = cwp;
    end
endmodule

// File: rtl/trap_vector.sv
// Handler PC / nPC from base address, nested flag and trap type.
// Assumes 64-bit addresses; the entry spacing is 32 bytes.
module trap_vector (
    input  logic [trap_pkg::ADDR_W-1:0] base,
    input  logic                        nested,
    input  logic [trap_pkg::TT_W-1:0]   tt,
    output logic [trap_pkg::ADDR_W-1:0] hpc,
    output logic [trap_pkg::ADDR_W-1:0] hnpc
);
    // Concatenate the table slot address and its second word.
    always_comb begin
        hpc  = {base[63:15], nested, tt, 5'b00000};
        hnpc = {base[63:15], nested, tt, 5'b00100};
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Trap entry sequencer: on an accepted request, pushes PC/nPC/type at the
// next level, forces the processor-state word, adjusts the window pointer
// and presents the handler target on a one-cycle strobe.
// Assumes NWIN is a power of two and trap return is handled elsewhere.
module trap_entry_seq #(
    parameter int MAX_TL = 5,
    parameter int NWIN   = 8,
    parameter int CWP_W  = $clog2(NWIN),
    parameter int TL_W   = $clog2(MAX_TL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [8:0]       trap_type,
    input  logic [63:0]      cur_pc,
    input  logic [63:0]      cur_npc,
    input  logic [63:0]      trap_base,
    input  logic [CWP_W-1:0] cur_cwp,
    input  logic [CWP_W-1:0] cansave,
    input  logic [9:0]       cur_pstate,
    input  logic             fpu_present,
    input  logic [TL_W-1:0]  rd_lvl,
    output logic [TL_W-1:0]  tl,
    output logic             err_mode,
    output logic             redir_valid,
    output logic [63:0]      redir_pc,
    output logic [63:0]      redir_npc,
    output logic [CWP_W-1:0] new_cwp,
    output logic [9:0]       new_pstate,
    output logic [63:0]      rd_tpc,
    output logic [63:0]      rd_tnpc,
    output logic [8:0]       rd_tt
);
    import trap_pkg::*;

    localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

    logic [TL_W-1:0]  tl_q;
    logic             err_q;
    logic             take, overflow;
    logic [63:0]      hpc, hnpc;
    logic [CWP_W-1:0] cwp_n;
    pstate_t          ps_in, ps_n;

    assign take     = trap_req && !err_q && (tl_q != TL_TOP);
    assign overflow = trap_req && !err_q && (tl_q == TL_TOP);
    assign ps_in    = pstate_t'(cur_pstate);

    // Force the handler configuration of the state word.
    always_comb begin
        ps_n      = ps_in;
        ps_n.red  = 1'b0;
        ps_n.pef  = fpu_present;
        ps_n.am   = 1'b0;
        ps_n.priv = 1'b1;
        ps_n.ie   = 1'b0;
        ps_n.ag   = 1'b1;
        ps_n.cle  = ps_in.tle;
    end

    trap_stack #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_stack (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (take),
        .wlvl (tl_q + TL_W'(1)),
        .wpc  (cur_pc),
        .wnpc (cur_npc),
        .wtt  (trap_type),
        .rlvl (rd_lvl),
        .rpc  (rd_tpc),
        .rnpc (rd_tnpc),
        .rtt  (rd_tt)
    );

    trap_cwp_adj #(.CWP_W(CWP_W)) u_cwp (
        .tt     (trap_type),
        .cwp    (cur_cwp),
        .cansave(cansave),
        .cwp_out(cwp_n)
    );

    trap_vector u_vec (
        .base  (trap_base),
        .nested(tl_q != '0),
        .tt    (trap_type),
        .hpc   (hpc),
        .hnpc  (hnpc)
    );

    // Trap level and sticky error mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (take)     tl_q  <= tl_q + TL_W'(1);
            if (overflow) err_q <= 1'b1;
        end
    end

    // Redirect strobe and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            redir_npc   <= '0;
            new_cwp     <= '0;
            new_pstate  <= '0;
        end else begin
            redir_valid <= take;
            if (take) begin
                redir_pc   <= hpc;
                redir_npc  <= hnpc;
                new_cwp    <= cwp_n;
                new_pstate <= ps_n;
            end
        end
    end

    assign tl       = tl_q;
    assign err_mode = err_q;
endmodule

// File: rtl/trap_entry_chk.sv
// Assertion checker for trap_entry_seq, attached by bind below.
module trap_entry_chk #(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic [8:0]      trap_type,
    input logic [9:0]      cur_pstate,
    input logic            fpu_present,
    input logic [TL_W-1:0] tl,
    input logic            err_mode,
    input logic            redir_valid,
    input logic [63:0]     redir_pc,
    input logic [63:0]     redir_npc,
    input logic [9:0]      new_pstate
);
    // R2
    tl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !err_mode && tl != TL_W'(MAX_TL)) |=> tl == TL_W'($past(tl) + 1'b1));

    // R3
    pstate_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (new_pstate[5:0] == {1'b1, 1'b0, 1'b1, 1'b0, $past(fpu_present), 1'b0}
                         && new_pstate[6] == $past(cur_pstate[7])
                         && new_pstate[9:7] == $past(cur_pstate[9:7])));

    // R7
    vec_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_pc[14] == ($past(tl) != '0) && redir_pc[13:5] == $past(trap_type)
                         && redir_pc[4:0] == 5'd0));

    // R8
    npc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> redir_npc == (redir_pc | 64'h4));

    // R9
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> $past(trap_req));

    // R10
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !err_mode && tl == TL_W'(MAX_TL)) |=> (err_mode && !redir_valid));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |=> (err_mode && $stable(tl) && !redir_valid));
endmodule

bind trap_entry_seq trap_entry_chk #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .trap_type  (trap_type),
    .cur_pstate (cur_pstate),
    .fpu_present(fpu_present),
    .tl         (tl),
    .err_mode   (err_mode),
    .redir_valid(redir_valid),
    .redir_pc   (redir_pc),
    .redir_npc  (redir_npc),
    .new_pstate (new_pstate)
);

// File: tb/trap_entry_seq_test.sv
// Scoreboard bench for trap_entry_seq.
module trap_entry_seq_test;
    localparam int MAX_TL = 5;
    localparam int CWP_W  = 3;
    localparam int TL_W   = 3;

    typedef struct {
        logic [63:0]      pc;
        logic [63:0]      npc;
        logic [CWP_W-1:0] cwp;
        logic [9:0]       ps;
        logic [TL_W-1:0]  tl;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trap_req = 1'b0;
    logic [8:0]       trap_type = '0;
    logic [63:0]      cur_pc = '0, cur_npc = '0, trap_base = '0;
    logic [CWP_W-1:0] cur_cwp = '0, cansave = '0;
    logic [9:0]       cur_pstate = '0;
    logic             fpu_present = 1'b0;
    logic [TL_W-1:0]  rd_lvl = '0;
    logic [TL_W-1:0]  tl;
    logic             err_mode, redir_valid;
    logic [63:0]      redir_pc, redir_npc, rd_tpc, rd_tnpc;
    logic [CWP_W-1:0] new_cwp;
    logic [9:0]       new_pstate;
    logic [8:0]       rd_tt;

    int   errors = 0;
    int   checks = 0;
    exp_t sb[$];
    int   model_tl = 0;

    always #4 clk = ~clk;

    trap_entry_seq uut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: presents one request for one cycle and queues what it must produce.
    task automatic trap(input logic [8:0] tt, input logic [CWP_W-1:0] cwp,
                        input logic [CWP_W-1:0] cs, input logic fpu, input string tag);
        exp_t e;
        logic [CWP_W-1:0] wc;
        @(negedge clk);
        trap_type   = tt;
        cur_pc      = {32'hA000_0000, 23'd0, tt};
        cur_npc     = {32'hB000_0000, 23'd0, tt};
        trap_base   = 64'h1234_5678_9ABC_DEF0;
        cur_cwp     = cwp;
        cansave     = cs;
        cur_pstate  = {2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
        fpu_present = fpu;
        trap_req    = 1'b1;
        if (model_tl < MAX_TL) begin
            if (tt == 9'h024)           wc = cwp + 3'd1;
            else if (tt[8:6] == 3'b010) wc = cwp + cs + 3'd2;
            else if (tt[8:6] == 3'b011) wc = cwp - 3'd1;
            else                        wc = cwp;
            e.pc  = {trap_base[63:15], model_tl != 0, tt, 5'd0};
            e.npc = {trap_base[63:15], model_tl != 0, tt, 5'd4};
            e.cwp = wc;
            e.ps  = {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, fpu, 1'b0};
            model_tl++;
            e.tl  = TL_W'(model_tl);
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    // Monitor: compares each strobe against the queue, in order.
    always @(negedge clk) begin
        if (rst_n && redir_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9/R10 unexpected redirect", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(redir_pc == e.pc, {"R7 pc ", e.tag}, redir_pc, e.pc);
                check(redir_npc == e.npc, {"R8 npc ", e.tag}, redir_npc, e.npc);
                check(new_cwp == e.cwp, {e.tag, " cwp"}, 64'(new_cwp), 64'(e.cwp));
                check(new_pstate == e.ps, {"R3 pstate ", e.tag}, 64'(new_pstate), 64'(e.ps));
                check(tl == e.tl, {"R2 tl ", e.tag}, 64'(tl), 64'(e.tl));
            end
        end
    end

    task automatic stack_chk(input int lvl, input logic [8:0] tt);
        @(negedge clk);
        rd_lvl = TL_W'(lvl);
        #1;
        check(rd_tt == tt, "R2 saved type", 64'(rd_tt), 64'(tt));
        check(rd_tpc == {32'hA000_0000, 23'd0, tt}, "R2 saved pc", rd_tpc, {32'hA000_0000, 23'd0, tt});
        check(rd_tnpc == {32'hB000_0000, 23'd0, tt}, "R2 saved npc", rd_tnpc, {32'hB000_0000, 23'd0, tt});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tl == 0, "R1 tl", 64'(tl), 64'd0);
        check(err_mode == 0, "R1 err", 64'(err_mode), 64'd0);
        check(redir_valid == 0, "R1 strobe", 64'(redir_valid), 64'd0);
        rd_lvl = 3'd1;
        #1;
        check(rd_tpc == 0 && rd_tt == 0, "R1 stack", rd_tpc, 64'd0);
        rst_n = 1'b1;

        trap(9'h034, 3'd3, 3'd1, 1'b1, "R6 other 0x034");  idle();
        trap(9'h024, 3'd7, 3'd0, 1'b0, "R4 clean wrap");   idle();
        trap(9'h080, 3'd5, 3'd6, 1'b1, "R5 spill wrap");   idle();
        trap(9'h0FF, 3'd0, 3'd2, 1'b1, "R6 fill wrap");    idle();
        trap(9'h1C0, 3'd4, 3'd2, 1'b0, "R6 other 0x1C0");  idle();
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R9 all strobes seen", 64'(sb.size()), 64'd0);
        check(tl == 3'd5, "R2 level five", 64'(tl), 64'd5);

        stack_chk(1, 9'h034);
        stack_chk(3, 9'h080);
        stack_chk(5, 9'h1C0);

        // R10 overflow at max level, then a further request ignored
        trap(9'h011, 3'd1, 3'd1, 1'b1, "R10 over"); idle();
        trap(9'h012, 3'd1, 3'd1, 1'b1, "R10 after"); idle();
        repeat (2) @(negedge clk);
        check(err_mode == 1'b1, "R10 err set", 64'(err_mode), 64'd1);
        check(tl == 3'd5, "R10 tl held", 64'(tl), 64'd5);
        stack_chk(5, 9'h1C0);

        // R9 back-to-back after reset
        @(negedge clk); rst_n = 1'b0; model_tl = 0;
        repeat (2) @(negedge clk);
        check(err_mode == 0 && tl == 0, "R1 re-reset", 64'(tl), 64'd0);
        rst_n = 1'b1;
        trap(9'h0A5, 3'd6, 3'd7, 1'b0, "R9 b2b first");
        trap(9'h0C1, 3'd2, 3'd0, 1'b1, "R9 b2b second");
        idle();
        @(negedge clk);
        check(redir_valid == 1'b0, "R9 strobe drops", 64'(redir_valid), 64'd0);
        check(sb.size() == 0, "R9 b2b both seen", 64'(sb.size()), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule